// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block drives a 32-bit external address bus for a dynamic RAM access in two steps. In the row step the full internal byte address goes straight to the bus. In the column step the bus carries the same address moved to the left by an amount that suits the device's column width. The three byte-offset bits stay where they are.

The shift amount is chosen separately for each access. At row time a 3-bit alignment code is read from input pins and stored. That stored code then sets the column layout for the rest of the access. The code stays in force until the next row-time strobe, so activity on the pins during the column step changes nothing. Strobe generation, refresh and data transfer are handled elsewhere.

Top module: `dram_addr_mux`

## Requirements
- R1: While `col_phase` is 0 (row step), `mem_addr` equals `int_addr` bit for bit, in the same cycle.
- R2: On a rising clock edge with `row_strobe` high, the value on `align_pins` is stored as the alignment code. On edges with `row_strobe` low the stored code does not change, whatever `align_pins` carries.
- R3: While `col_phase` is 1 and the stored code is 3'b000, `mem_addr` equals `int_addr` with no shift.
- R4: While `col_phase` is 1 and the stored code c is nonzero, `mem_addr[2:0]` equals `int_addr[2:0]`.
- R5: While `col_phase` is 1 and the stored code c is nonzero, address bit k (k ≥ 3) appears on `mem_addr[k+7+c]` when k+7+c ≤ 31. Bits that would land above pin 31 are dropped.
- R6: While `col_phase` is 1 and the stored code c is nonzero, the gap pins 3 through 9+c are driven to 0.
- R7: A synchronous active-high `rst` sets the stored code to 3'b000. After reset and before any row-time strobe, the column step therefore outputs the address unshifted.
- R8: The code-to-shift mapping runs from 3'b001, which puts address bit 3 on pin 11 (a shift of 8), to 3'b111, which puts it on pin 17 (a shift of 14). Each code in between adds one position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_addr | input | 32 | Internal byte address of the access |
| col_phase | input | 1 | 0 = row step, 1 = column step |
| row_strobe | input | 1 | Marks row time; the alignment code is stored on this edge |
| align_pins | input | 3 | Alignment code presented at row time |
| mem_addr | output | 32 | Multiplexed external address |

## Verification
The column mapping is tried with several kinds of address:
- A single set bit 3 moves one bit alone, so it shows the exact shift for each code.
- Bit 31 alone shows that bits running past the top of the bus are dropped.
- An all-ones address shows that every gap pin is driven to zero while the offset bits survive.
- Random addresses under random codes cover the general mapping.

Changing `align_pins` during the column step separates a stored code from a combinational path out of the pins. A reset issued after a nonzero code shows that the stored code really returns to zero.

// File: rtl/dram_addr_mux_pkg.sv
package dram_addr_mux_pkg;

    localparam int ADDR_W     = 32;
    localparam int CODE_W     = 3;
    localparam int OFFS_W     = 3;
    localparam int BASE_SHIFT = 7;
    localparam int NCODES     = 1 << CODE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        PH_ROW = 1'b0,
        PH_COL = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   strobe;
        code_t  pins;
    } bus_ctl_t;

    // Left shift applied to the upper address field for a given code.
    function automatic int col_shift(input int code);
        return (code == 0) ? 0 : BASE_SHIFT + code;
    endfunction

    // Pins left empty between the offset field and the shifted field.
    function automatic addr_t gap_mask(input int code);
        logic [2*ADDR_W-1:0] m;
        m = ((64'd1 << col_shift(code)) - 64'd1) << OFFS_W;
        return m[ADDR_W-1:0];
    endfunction

    function automatic addr_t low_mask();
        return addr_t'((1 << OFFS_W) - 1);
    endfunction

endpackage

// File: rtl/align_code_reg.sv
module align_code_reg
    import dram_addr_mux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  code_t pins,
    output code_t code
);

    code_t code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (strobe)
            code_q <= pins;
    end

    assign code = code_q;

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (code == $past(pins)));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(code));

    logic seen_edge;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        if (seen_edge && $past(rst))
            a_r7_reset_clear: assert (code == '0);
    end

endmodule

// File: rtl/col_shifter.sv
module col_shifter
    import dram_addr_mux_pkg::*;
(
    input  addr_t addr,
    input  code_t code,
    output addr_t col_addr
);

    addr_t cand [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_cand
        if (g == 0) begin : g_plain
            assign cand[g] = addr;
        end else begin : g_shift
            localparam int SH = BASE_SHIFT + g;
            addr_t upper;
            assign upper   = addr & ~low_mask();
            assign cand[g] = (upper << SH) | (addr & low_mask());
        end
    end

    assign col_addr = cand[code];

    always_comb begin
        if (code != '0) begin
            a_r6_gap_zero: assert ((col_addr & gap_mask(int'(code))) == '0);
        end
        if (code == '0) begin
            a_r3_no_shift: assert (col_addr == addr);
        end
    end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_addr_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] int_addr,
    input  logic        col_phase,
    input  logic        row_strobe,
    input  logic [2:0]  align_pins,
    output logic [31:0] mem_addr
);

    bus_ctl_t ctl;
    code_t    code;
    addr_t    col_addr;

    assign ctl.phase  = phase_e'(col_phase);
    assign ctl.strobe = row_strobe;
    assign ctl.pins   = align_pins;

    align_code_reg u_code (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctl.strobe),
        .pins   (ctl.pins),
        .code   (code)
    );

    col_shifter u_shift (
        .addr     (int_addr),
        .code     (code),
        .col_addr (col_addr)
    );

    always_comb begin
        unique case (ctl.phase)
            PH_ROW:  mem_addr = int_addr;
            PH_COL:  mem_addr = col_addr;
            default: mem_addr = int_addr;
        endcase
    end

    a_r1_row_passthru: assert property (@(posedge clk) disable iff (rst)
        !col_phase |-> (mem_addr == int_addr));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
        col_phase |-> (mem_addr[2:0] == int_addr[2:0]));

endmodule

// File: tb/sim_dram_addr_mux.sv
module sim_dram_addr_mux;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] int_addr;
    logic        col_phase;
    logic        row_strobe;
    logic [2:0]  align_pins;
    logic [31:0] mem_addr;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dram_addr_mux u0 (
        .clk        (clk),
        .rst        (rst),
        .int_addr   (int_addr),
        .col_phase  (col_phase),
        .row_strobe (row_strobe),
        .align_pins (align_pins),
        .mem_addr   (mem_addr)
    );

    function automatic logic [31:0] exp_col(input logic [31:0] a, input int c);
        logic [31:0] r;
        if (c == 0) return a;
        r = '0;
        r[2:0] = a[2:0];
        for (int k = 3; k < 32; k++) begin
            if (k + 7 + c <= 31) r[k + 7 + c] = a[k];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_vec++;
        if (mem_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
        end
    endtask

    // Row step with code c, then column step with pins scrambled.
    task automatic access(input logic [31:0] a, input logic [2:0] c, input string req);
        @(negedge clk);
        int_addr = a; col_phase = 1'b0; row_strobe = 1'b1; align_pins = c;
        #1 check("R1", a);
        @(negedge clk);
        row_strobe = 1'b0; col_phase = 1'b1; align_pins = 3'($urandom);
        #1 check(req, exp_col(a, int'(c)));
        @(negedge clk);
        align_pins = ~align_pins;
        #1 check("R2", exp_col(a, int'(c)));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; int_addr = '0; col_phase = 1'b0; row_strobe = 1'b0; align_pins = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: column step straight after reset is unshifted
        int_addr = 32'hDEAD_BEEF; col_phase = 1'b1; align_pins = 3'b101;
        #1 check("R7", 32'hDEAD_BEEF);
        // R8: bit 3 alone for each code
        for (int c = 1; c < 8; c++) access(32'h0000_0008, 3'(c), "R8");
        access(32'h0000_0008, 3'b001, "R8");
        n_vec++; if (mem_addr !== 32'h0000_0800) begin n_fail++; $display("FAIL R8: %h expected 00000800", mem_addr); end
        access(32'h0000_0008, 3'b111, "R8");
        n_vec++; if (mem_addr !== 32'h0002_0000) begin n_fail++; $display("FAIL R8: %h expected 00020000", mem_addr); end
        // R5: top bit dropped
        access(32'h8000_0000, 3'b001, "R5");
        access(32'h8000_0007, 3'b111, "R4");
        // R6: all ones, gap pins zero
        for (int c = 1; c < 8; c++) access(32'hFFFF_FFFF, 3'(c), "R6");
        // R3: code zero
        access(32'h1234_5678, 3'b000, "R3");
        // R7: reset after a nonzero code
        access(32'h0F0F_0F0F, 3'b110, "R5");
        @(negedge clk); rst = 1'b1; row_strobe = 1'b0;
        @(negedge clk); rst = 1'b0; col_phase = 1'b1; int_addr = 32'hA5A5_0F0F;
        #1 check("R7", 32'hA5A5_0F0F);
        // random mix
        for (int i = 0; i < 300; i++) access($urandom, 3'($urandom), "R5");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule